// File: doc/BRIEF.md
# Video Register Interface with Power-Up Warmup

This block is the processor-facing register window of a video controller, covering the period after power-up and reset. The processor reaches it through a chip select, a 3-bit register offset, read and write strobes and an 8-bit data bus. Every access and every internal count takes effect only on clock edges where the processor clock enable is high. The window holds a vertical-blank status flag that clears when it is read, a 16-bit address loaded by two byte writes, and a control and a mask byte.

After reset the block runs a warmup interval. During that interval writes to the control, mask and address registers are dropped without any sign. The interval lasts longer than the delay to the first new vertical-blank flag. Reset does not clear the flag. A program that takes two flag observations as proof of readiness can therefore see a stale flag, then the first real one, and still write while writes are blocked. A dummy status read before the wait removes the stale flag.

The power-up value of the flag comes from a configuration input. The assembled address is brought out on a debug port.

Top module: `vreg_warmup`

## Requirements
- R1: Reads return data combinationally while `cs` and `rd` are high. Offset 2 returns the vertical-blank flag in bit 7 with bits 6..0 zero. Offset 0 returns the control byte and offset 1 the mask byte. Any other offset, or no read, returns 0x00.
- R2: A status read (offset 2) on an enabled edge clears the flag. If the flag is set on that same edge, the set wins.
- R3: The first reset after power-up loads the flag from `vbl_init`. Every later reset leaves the flag unchanged.
- R4: After reset the flag is set on the enabled edge that completes the 27383rd enabled clock. After that it is set every `FRAME_CLKS` enabled clocks, 29781 by default.
- R5: Writes to offsets 0, 1 and 6 are dropped while fewer than 29658 enabled clocks have passed since reset. Writes are accepted from that point on.
- R6: Address writes alternate between high byte and low byte, starting with the high byte. Two writes of 0x11 give 0x1111. A dropped write does not advance the toggle.
- R7: A status read returns the address toggle to the high-byte state.
- R8: Reset clears the control byte, the mask byte and the address, and sets the toggle to the high-byte state.
- R9: On edges where `cpu_ce` is low, no access takes effect and no count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_ce | input | 1 | Processor clock enable |
| vbl_init | input | 1 | Flag value loaded by the first reset after power-up |
| cs | input | 1 | Chip select |
| reg_sel | input | 3 | Register offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| dbg_addr | output | 16 | Assembled address, for observation |

## Verification
Two situations are hard to reach from the ports. The first is a reset applied while the flag is set. The second is a status read landing on the exact edge where the flag is set again. The bench keeps its own count of enabled clocks since reset. It uses that count to hold off until the flag has just risen and then asserts reset. It also uses the count to place a status read on the edge that completes a frame period. In the same run, a program waits for the first flag and writes the address at once, which reproduces the case where writes are still blocked.

// File: rtl/vreg_warmup.sv
module vreg_warmup #(
  parameter int VBL_FIRST  = 27383,
  parameter int WARM_CLKS  = 29658,
  parameter int FRAME_CLKS = 29781
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_ce,
  input  logic        vbl_init,
  input  logic        cs,
  input  logic [2:0]  reg_sel,
  input  logic        rd,
  input  logic        wr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [15:0] dbg_addr
);
  localparam int CMAX = (VBL_FIRST > FRAME_CLKS) ?
                        ((VBL_FIRST > WARM_CLKS) ? VBL_FIRST : WARM_CLKS) :
                        ((FRAME_CLKS > WARM_CLKS) ? FRAME_CLKS : WARM_CLKS);
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] FIRST_LAST = CW'(VBL_FIRST - 1);
  localparam logic [CW-1:0] FRAME_LAST = CW'(FRAME_CLKS - 1);
  localparam logic [CW-1:0] WARM_LAST  = CW'(WARM_CLKS - 1);

  logic          powered = 1'b0;
  logic          vbl, first_pend, warm, tog;
  logic [CW-1:0] fcnt, wcnt;
  logic [7:0]    ctrl, mask;
  logic [15:0]   addr;

  wire acc_rd = cpu_ce && cs && rd;
  wire acc_wr = cpu_ce && cs && wr && !warm;
  wire st_rd  = acc_rd && (reg_sel == 3'd2);
  wire hit    = cpu_ce && (fcnt == (first_pend ? FIRST_LAST : FRAME_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      powered    <= 1'b1;
      if (!powered) vbl <= vbl_init;
      fcnt       <= '0;
      wcnt       <= '0;
      first_pend <= 1'b1;
      warm       <= 1'b1;
      tog        <= 1'b0;
      ctrl       <= '0;
      mask       <= '0;
      addr       <= '0;
    end else begin
      if (hit) vbl <= 1'b1;
      else if (st_rd) vbl <= 1'b0;

      if (cpu_ce) begin
        fcnt <= hit ? '0 : fcnt + 1'b1;
        if (hit) first_pend <= 1'b0;
        if (warm) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WARM_LAST) warm <= 1'b0;
        end
      end

      if (acc_wr) begin
        case (reg_sel)
          3'd0: ctrl <= wdata;
          3'd1: mask <= wdata;
          3'd6: begin
            if (tog) addr[7:0] <= wdata;
            else     addr[15:8] <= wdata;
            tog <= !tog;
          end
          default: ;
        endcase
      end
      if (st_rd) tog <= 1'b0;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (cs && rd) begin
      case (reg_sel)
        3'd0:    rdata = ctrl;
        3'd1:    rdata = mask;
        3'd2:    rdata = {vbl, 7'b0};
        default: rdata = 8'h00;
      endcase
    end
  end

  assign dbg_addr = addr;
endmodule

// File: rtl/vreg_warmup_chk.sv
module vreg_warmup_chk #(
  parameter int CW = 15,
  parameter int WARM_CLKS = 29658
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_ce,
  input logic          powered,
  input logic          vbl,
  input logic          warm,
  input logic          tog,
  input logic          hit,
  input logic          st_rd,
  input logic [CW-1:0] wcnt,
  input logic [15:0]   dbg_addr
);
  assert_clear_on_read_R2: assert property (@(posedge clk) disable iff (rst)
    (st_rd && !hit) |=> !vbl);

  assert_set_wins_R2: assert property (@(posedge clk) disable iff (rst)
    hit |=> vbl);

  assert_reset_keeps_flag_R3: assert property (@(posedge clk)
    (rst && powered) |=> (vbl == $past(vbl)));

  assert_rise_on_hit_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(vbl) |-> $past(hit));

  assert_drop_addr_R5: assert property (@(posedge clk) disable iff (rst)
    warm |=> $stable(dbg_addr));

  assert_warm_length_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(warm) |-> ($past(wcnt) == CW'(WARM_CLKS - 1)));

  assert_toggle_idle_R6: assert property (@(posedge clk) disable iff (rst)
    warm |=> !tog);

  assert_reset_addr_R8: assert property (@(posedge clk)
    rst |=> (dbg_addr == 16'h0000 && !tog));

  assert_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !cpu_ce |=> ($stable(vbl) && $stable(dbg_addr) && $stable(tog)));
endmodule

bind vreg_warmup vreg_warmup_chk #(.CW(CW), .WARM_CLKS(WARM_CLKS)) u_chk (
  .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .powered(powered), .vbl(vbl),
  .warm(warm), .tog(tog), .hit(hit), .st_rd(st_rd), .wcnt(wcnt),
  .dbg_addr(dbg_addr)
);

// File: tb/vreg_warmup_bench.sv
`timescale 1ns/1ps
module vreg_warmup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FIRST = 27383, WARM = 29658, FRAME = 29781;

  logic clk = 0, rst = 1, cpu_ce = 1, vbl_init = 1, cs = 0, rd = 0, wr = 0;
  logic [2:0] reg_sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [15:0] dbg_addr;

  vreg_warmup u_vreg_warmup (.clk(clk), .rst(rst), .cpu_ce(cpu_ce), .vbl_init(vbl_init),
    .cs(cs), .reg_sel(reg_sel), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .dbg_addr(dbg_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, misses = 0, cycles = 0;
  bit started = 0, m_powered = 0, m_flag = 0, m_tog = 0;
  int m_t = 0;
  logic [15:0] m_addr = 0;
  logic [7:0] m_ctrl = 0, m_mask = 0;
  string cur_req = "R8";

  always @(posedge clk) begin
    cycles++;
    started = 1;
    if (rst) begin
      if (!m_powered) m_flag = vbl_init;
      m_powered = 1; m_t = 0; m_tog = 0; m_addr = 0; m_ctrl = 0; m_mask = 0;
    end else if (cpu_ce) begin
      bit ev, rds;
      ev  = (m_t + 1 >= FIRST) && (((m_t + 1 - FIRST) % FRAME) == 0);
      rds = cs && rd && reg_sel == 3'd2;
      if (cs && wr && m_t >= WARM) begin
        if (reg_sel == 3'd0) m_ctrl = wdata;
        if (reg_sel == 3'd1) m_mask = wdata;
        if (reg_sel == 3'd6) begin
          if (m_tog) m_addr[7:0] = wdata; else m_addr[15:8] = wdata;
          m_tog = !m_tog;
        end
      end
      if (rds) m_tog = 0;
      if (ev) m_flag = 1; else if (rds) m_flag = 0;
      m_t++;
    end
  end

  function automatic logic [7:0] exp_rd();
    if (!(cs && rd)) return 8'h00;
    case (reg_sel)
      3'd0: return m_ctrl;
      3'd1: return m_mask;
      3'd2: return {m_flag, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) if (started) begin
    vectors++;
    if (rdata !== exp_rd() || dbg_addr !== m_addr) begin
      misses++;
      $display("FAIL %s t=%0d rdata=%h/%h addr=%h/%h (actual/expected)",
               cur_req, m_t, rdata, exp_rd(), dbg_addr, m_addr);
    end
  end

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus(bit r, bit w, logic [2:0] s, logic [7:0] d);
    @(posedge clk); #1;
    cs = r | w; rd = r; wr = w; reg_sel = s; wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; cs = 0; rd = 0; wr = 0;
    end
  endtask

  task automatic rd_check(string req, logic [2:0] s, logic [7:0] exp);
    bus(1, 0, s, 0);
    @(negedge clk);
    check(req, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic do_reset(int n);
    @(posedge clk); #1; rst = 1; cs = 0; rd = 0; wr = 0;
    idle(n);
    rst = 0;
  endtask

  initial begin
    idle(3);
    rst = 0;
    cur_req = "R3"; rd_check("R3 power flag", 3'd2, 8'h80);
    cur_req = "R2"; rd_check("R2 cleared", 3'd2, 8'h00);
    rd_check("R1 other offset", 3'd5, 8'h00);
    cur_req = "R3"; do_reset(2);
    rd_check("R3 clear kept", 3'd2, 8'h00);
    cur_req = "R8"; check("R8 addr", dbg_addr, 16'h0000);
    cur_req = "R5";
    bus(0, 1, 3'd0, 8'h05); bus(0, 1, 3'd1, 8'h06);
    bus(0, 1, 3'd6, 8'h11); bus(0, 1, 3'd6, 8'h11); idle(1);
    rd_check("R5 ctrl dropped", 3'd0, 8'h00);
    rd_check("R5 mask dropped", 3'd1, 8'h00);
    check("R5 addr dropped", dbg_addr, 16'h0000);
    cur_req = "R4";
    do begin bus(1, 0, 3'd2, 0); @(negedge clk); end while (!rdata[7]);
    check("R4 first flag time", 16'(m_t), 16'(FIRST));
    cur_req = "R5";
    bus(0, 1, 3'd6, 8'h11); bus(0, 1, 3'd6, 8'h11); idle(1);
    check("R5 naive write dropped", dbg_addr, 16'h0000);
    while (m_t < WARM) idle(1);
    cur_req = "R6";
    bus(0, 1, 3'd6, 8'h11); bus(0, 1, 3'd6, 8'h11); idle(1);
    check("R6 addr 1111", dbg_addr, 16'h1111);
    cur_req = "R5";
    bus(0, 1, 3'd0, 8'h5A); bus(0, 1, 3'd1, 8'h3C);
    rd_check("R5 ctrl accepted", 3'd0, 8'h5A);
    rd_check("R1 mask readback", 3'd1, 8'h3C);
    cur_req = "R7";
    bus(0, 1, 3'd6, 8'hAB); bus(1, 0, 3'd2, 0);
    bus(0, 1, 3'd6, 8'hCD); bus(0, 1, 3'd6, 8'hEF); idle(1);
    check("R7 toggle reset", dbg_addr, 16'hCDEF);
    cur_req = "R6";
    bus(0, 1, 3'd6, 8'h22); idle(1);
    check("R6 high byte", dbg_addr, 16'h22EF);
    bus(0, 1, 3'd6, 8'h33); idle(1);
    check("R6 low byte", dbg_addr, 16'h2233);
    cur_req = "R9";
    @(posedge clk); #1; cpu_ce = 0;
    cs = 1; wr = 1; rd = 0; reg_sel = 3'd6; wdata = 8'h44;
    idle(0);
    for (int i = 0; i < 50; i++) begin @(posedge clk); #1; end
    cs = 0; wr = 0;
    check("R9 gated write", dbg_addr, 16'h2233);
    cpu_ce = 1;
    cur_req = "R2";
    while (m_t != FIRST + FRAME - 1) begin @(posedge clk); #1; end
    cs = 1; rd = 1; wr = 0; reg_sel = 3'd2;
    idle(1);
    rd_check("R2 set wins", 3'd2, 8'h80);
    rd_check("R2 read clears", 3'd2, 8'h00);
    cur_req = "R4";
    while (m_t < FIRST + 2*FRAME) idle(1);
    cur_req = "R3"; do_reset(2);
    rd_check("R3 set kept over reset", 3'd2, 8'h80);
    rd_check("R3 dummy read clears", 3'd2, 8'h00);
    idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  always @(posedge clk) if (cycles >= 200000) begin
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule